// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to eight peripheral interrupt lines, holds each captured request until it is serviced, and presents one maskable interrupt line to a processor. Three state vectors shape its decisions: pending requests, per-input mask bits and levels currently in service. Among the unmasked pending requests the one on the lowest-numbered input wins. That winner may interrupt the processor only when it outranks every level already in service, so a high-priority source can nest inside a lower-priority handler.

The processor acknowledges with two low pulses on an active-low acknowledge line. The first pulse commits the winner: its pending bit drops and its in-service bit is set. During the second pulse the block presents an 8-bit vector on its data output with the output enable raised. The vector's upper bits come from a programmable base and its low bits are the input number. A small synchronous write port sets the mask and the base, and it accepts end-of-interrupt commands that retire in-service levels one at a time, either the most urgent one or a named one.

Top module: `vic_ctrl`

## Requirements
- R1: After reset every input is masked (mask = 0xFF), the vector base is 0x08, no request or in-service level is held, `intr_o` and `vec_oe_o` are low and `vec_o` is zero.
- R2: A request is captured only on a rising edge of its input. A line that stays high after its request is serviced raises no new request.
- R3: A write to address 0 loads the mask (bit i = 1 masks input i). A masked request never raises `intr_o`, but it stays pending and raises `intr_o` once it is unmasked.
- R4: Among unmasked pending requests, input 0 has the highest priority and input 7 the lowest, and the acknowledged vector names the highest-priority one.
- R5: On the first falling edge of `inta_n_i` the winner's pending bit clears and its in-service bit sets. From the second falling edge until `inta_n_i` rises, `vec_oe_o` is high and `vec_o` = {base[7:3], input[2:0]}. At all other times `vec_oe_o` is low and `vec_o` is zero.
- R6: `intr_o` is high exactly when the highest-priority unmasked pending request has a lower input number than every in-service level, or when nothing is in service.
- R7: A write to address 2 with data bit 3 = 0 (non-specific end of interrupt) clears the in-service bit with the lowest input number.
- R8: A write to address 2 with data bit 3 = 1 (specific end of interrupt) clears the in-service bit named by data bits [2:0].
- R9: A first acknowledge pulse that arrives while `intr_o` is low changes no pending or in-service bit, and the second pulse returns {base[7:3], 3'b111}.
- R10: A write to address 1 loads the vector base. A write to address 3 changes neither the mask nor the base.
- R11: Base bits [2:0] do not reach the vector. Only base bits [7:3] appear in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Peripheral request lines, rising-edge captured |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 mask, 1 base, 2 end of interrupt) |
| wr_data_i | input | 8 | Register write data |
| inta_n_i | input | 1 | Active-low interrupt acknowledge from the processor |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector value, zero when not driven |
| vec_oe_o | output | 1 | Vector drive enable (bus released when low) |

## Verification
The bench builds the block with its defaults: eight inputs, an 8-bit data path and a two-stage input synchronizer. With those values the full 3-bit index field, the spurious index 7 and the whole base field are all exercised. Because requests cross two synchronizer stages, the bench lets each input change settle for four cycles before it checks. That lets its reference model treat every operation as atomic while the nesting depth, the ordering of end-of-interrupt commands and simultaneous rising edges are driven both by directed cases and by seeded random sequences.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int unsigned REG_ADDR_W = 2;
   localparam logic [REG_ADDR_W-1:0] ADDR_MASK = 2'd0;
   localparam logic [REG_ADDR_W-1:0] ADDR_BASE = 2'd1;
   localparam logic [REG_ADDR_W-1:0] ADDR_EOI  = 2'd2;
endpackage

// File: rtl/vic_irq_capture.sv
module vic_irq_capture #(
   parameter int unsigned N_IRQ       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] irq_i,
   output logic [N_IRQ-1:0] rise_o
);
   logic [N_IRQ-1:0] lvl;
   logic [N_IRQ-1:0] prev_q;

   if (SYNC_STAGES == 0) begin : g_direct
      assign lvl = irq_i;
   end else begin : g_sync
      logic [N_IRQ-1:0] stg_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) stg_q[s] <= '0;
         end else begin
            stg_q[0] <= irq_i;
            for (int s = 1; s < SYNC_STAGES; s++) stg_q[s] <= stg_q[s-1];
         end
      end
      assign lvl = stg_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   assign rise_o = lvl & ~prev_q;
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
   parameter int unsigned N     = 8,
   localparam int unsigned IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     vec_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/vic_ack_seq.sv
module vic_ack_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic inta_n_i,
   output logic first_o,
   output logic second_o,
   output logic drive_o
);
   logic prev_q;
   logic phase_q;
   logic drive_q;
   logic fall;

   assign fall     = prev_q & ~inta_n_i;
   assign first_o  = fall & ~phase_q;
   assign second_o = fall & phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b1;
         phase_q <= 1'b0;
         drive_q <= 1'b0;
      end else begin
         prev_q <= inta_n_i;
         if (fall) phase_q <= ~phase_q;
         if (second_o)      drive_q <= 1'b1;
         else if (inta_n_i) drive_q <= 1'b0;
      end
   end

   assign drive_o = drive_q;
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
   import vic_pkg::*;
#(
   parameter int unsigned    N_IRQ       = 8,
   parameter int unsigned    DW          = 8,
   parameter int unsigned    SYNC_STAGES = 2,
   parameter logic [7:0]     BASE_RST    = 8'h08,
   localparam int unsigned   IDX_W       = $clog2(N_IRQ)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_IRQ-1:0]      irq_i,
   input  logic                  wr_en_i,
   input  logic [REG_ADDR_W-1:0] wr_addr_i,
   input  logic [DW-1:0]         wr_data_i,
   input  logic                  inta_n_i,
   output logic                  intr_o,
   output logic [DW-1:0]         vec_o,
   output logic                  vec_oe_o
);
   if (N_IRQ < 2 || (1 << IDX_W) != N_IRQ) begin : g_bad_nirq
      $error("vic_ctrl: N_IRQ must be a power of two of at least 2");
   end
   if (N_IRQ > DW || IDX_W + 1 > DW) begin : g_bad_dw
      $error("vic_ctrl: DW too narrow for mask and command fields");
   end
   if (DW != 8) begin : g_bad_base
      $error("vic_ctrl: BASE_RST is sized for an 8-bit data path");
   end

   logic [N_IRQ-1:0]  irq_rise;
   logic [N_IRQ-1:0]  req_q, isr_q, mask_q, elig;
   logic [N_IRQ-1:0]  set_vec, eoi_clr;
   logic [DW-1:IDX_W] base_q;
   logic              req_any, isr_any, grant;
   logic [IDX_W-1:0]  req_idx, isr_idx, ack_idx_q;
   logic              ack_first, ack_second, ack_drive;
   logic              wr_mask, wr_base, wr_eoi;

   vic_irq_capture #(.N_IRQ(N_IRQ), .SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_i  (irq_i),
      .rise_o (irq_rise)
   );

   assign elig = req_q & ~mask_q;

   vic_prio_enc #(.N(N_IRQ)) u_req_enc (
      .vec_i (elig),
      .any_o (req_any),
      .idx_o (req_idx)
   );

   vic_prio_enc #(.N(N_IRQ)) u_isr_enc (
      .vec_i (isr_q),
      .any_o (isr_any),
      .idx_o (isr_idx)
   );

   vic_ack_seq u_ack (
      .clk      (clk),
      .rst_n    (rst_n),
      .inta_n_i (inta_n_i),
      .first_o  (ack_first),
      .second_o (ack_second),
      .drive_o  (ack_drive)
   );

   // A request outranks the in-service set when its index is smaller.
   assign intr_o = req_any && (!isr_any || (req_idx < isr_idx));

   assign wr_mask = wr_en_i && (wr_addr_i == ADDR_MASK);
   assign wr_base = wr_en_i && (wr_addr_i == ADDR_BASE);
   assign wr_eoi  = wr_en_i && (wr_addr_i == ADDR_EOI);
   assign grant   = ack_first && intr_o;

   always_comb begin
      set_vec = '0;
      if (grant) set_vec[req_idx] = 1'b1;
   end

   always_comb begin
      eoi_clr = '0;
      if (wr_eoi) begin
         if (wr_data_i[IDX_W])  eoi_clr[wr_data_i[IDX_W-1:0]] = 1'b1;
         else if (isr_any)      eoi_clr[isr_idx] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q     <= '0;
         isr_q     <= '0;
         mask_q    <= '1;
         base_q    <= BASE_RST[DW-1:IDX_W];
         ack_idx_q <= '1;
      end else begin
         req_q <= (req_q & ~set_vec) | irq_rise;
         isr_q <= (isr_q & ~eoi_clr) | set_vec;
         if (wr_mask) mask_q <= wr_data_i[N_IRQ-1:0];
         if (wr_base) base_q <= wr_data_i[DW-1:IDX_W];
         if (ack_first) ack_idx_q <= grant ? req_idx : '1;
      end
   end

   assign vec_oe_o = ack_drive;
   assign vec_o    = ack_drive ? {base_q, ack_idx_q} : '0;

   logic unused_second;
   assign unused_second = ack_second;
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
   parameter int unsigned N_IRQ = 8,
   parameter int unsigned DW    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             inta_n,
   input logic             intr,
   input logic             vec_oe,
   input logic [DW-1:0]    vec,
   input logic [N_IRQ-1:0] req_q,
   input logic [N_IRQ-1:0] isr_q,
   input logic [N_IRQ-1:0] mask_q,
   input logic             ack_first,
   input logic             eoi_wr,
   input logic             eoi_spec
);
   a_r5_drive_in_low_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe |-> !$past(inta_n));

   a_r5_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_oe |-> (vec == '0));

   a_r3_all_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !intr);

   a_r6_intr_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      intr |-> (|(req_q & ~mask_q)));

   a_r7_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && !eoi_spec && !ack_first && (|isr_q))
      |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));

   a_r9_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_first && !intr && !eoi_wr) |=> (isr_q == $past(isr_q)));
endmodule

bind vic_ctrl vic_ctrl_chk #(.N_IRQ(N_IRQ), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .inta_n    (inta_n_i),
   .intr      (intr_o),
   .vec_oe    (vec_oe_o),
   .vec       (vec_o),
   .req_q     (req_q),
   .isr_q     (isr_q),
   .mask_q    (mask_q),
   .ack_first (ack_first),
   .eoi_wr    (wr_eoi),
   .eoi_spec  (wr_data_i[IDX_W])
);

// File: tb/vic_ctrl_test.sv
`timescale 1ns/1ps
module vic_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq = '0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       inta_n = 1'b1;
   logic       intr;
   logic [7:0] vec;
   logic       vec_oe;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] m_req = '0, m_isr = '0, m_mask = 8'hFF, m_base = 8'h08;
   logic [7:0] got_vec;

   always #10 clk = ~clk;

   vic_ctrl uut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .wr_en_i(wr_en),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .inta_n_i(inta_n),
      .intr_o(intr), .vec_o(vec), .vec_oe_o(vec_oe)
   );

   function automatic int low_idx(logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return 8;
   endfunction

   function automatic logic exp_intr();
      int r, s;
      r = low_idx(m_req & ~m_mask);
      s = low_idx(m_isr);
      return (r < 8) && (r < s);
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic chk_intr(input string tag);
      chk(intr == exp_intr(), tag, 32'(intr), 32'(exp_intr()));
   endtask

   task automatic set_irq(input logic [7:0] lvl);
      logic [7:0] rise;
      @(negedge clk);
      rise = lvl & ~irq;
      irq = lvl;
      repeat (4) @(negedge clk);
      m_req |= rise;
   endtask

   task automatic do_write(input logic [1:0] a, input logic [7:0] d);
      int k;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      case (a)
         2'd0: m_mask = d;
         2'd1: m_base = d;
         2'd2: begin
            if (d[3]) m_isr[d[2:0]] = 1'b0;
            else begin
               k = low_idx(m_isr);
               if (k < 8) m_isr[k] = 1'b0;
            end
         end
         default: ;
      endcase
   endtask

   task automatic do_ack(input string tag);
      logic [7:0] exp_v;
      int w;
      @(negedge clk);
      if (exp_intr()) begin
         w = low_idx(m_req & ~m_mask);
         m_req[w] = 1'b0;
         m_isr[w] = 1'b1;
      end else w = 7;
      inta_n = 1'b0;
      @(negedge clk);
      inta_n = 1'b1;
      @(negedge clk);
      inta_n = 1'b0;
      @(negedge clk);
      exp_v = {m_base[7:3], 3'(w)};
      got_vec = vec;
      chk(vec_oe == 1'b1, {tag, " R5 oe during second pulse"}, 32'(vec_oe), 32'd1);
      chk(vec == exp_v, {tag, " R5 vector"}, 32'(vec), 32'(exp_v));
      inta_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(vec_oe == 1'b0 && vec == 8'h00, {tag, " R5 bus released"}, {23'd0, vec_oe, vec}, 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0000_5A17));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(intr == 1'b0, "R1 intr after reset", 32'(intr), 32'd0);
      chk(vec_oe == 1'b0 && vec == 8'h00, "R1 bus after reset", {23'd0, vec_oe, vec}, 32'd0);

      // R3 masked request latched, then released by unmask
      set_irq(8'h08);
      chk_intr("R3 masked request silent");
      do_write(2'd0, 8'h00);
      chk_intr("R3 unmask raises intr");
      chk(intr == 1'b1, "R3 intr literal", 32'(intr), 32'd1);
      do_ack("R1 base reset value");
      chk(got_vec == 8'h0B, "R1 vector with reset base", 32'(got_vec), 32'h0B);
      chk_intr("R6 in-service blocks itself");

      // R6 nesting
      set_irq(8'h28);
      chk(intr == 1'b0, "R6 lower request held", 32'(intr), 32'd0);
      set_irq(8'h2A);
      chk(intr == 1'b1, "R6 higher request nests", 32'(intr), 32'd1);
      do_ack("R6 nested ack");
      chk(got_vec == 8'h09, "R4 nested vector", 32'(got_vec), 32'h09);

      // R7 non-specific EOI retires levels in priority order
      do_write(2'd1, 8'hA5);
      do_write(2'd2, 8'h00);
      chk(intr == 1'b0, "R7 first EOI leaves level 3", 32'(intr), 32'd0);
      do_write(2'd2, 8'h00);
      chk(intr == 1'b1, "R7 second EOI frees level 5", 32'(intr), 32'd1);
      do_ack("R11 base low bits");
      chk(got_vec == 8'hA5, "R11 vector uses base[7:3]", 32'(got_vec), 32'hA5);

      // R8 specific EOI
      set_irq(8'h6A);
      chk(intr == 1'b0, "R8 level 6 held behind 5", 32'(intr), 32'd0);
      do_write(2'd2, 8'h0D);
      chk(intr == 1'b1, "R8 specific EOI level 5", 32'(intr), 32'd1);
      do_ack("R8 ack level 6");
      chk(got_vec == 8'hA6, "R8 vector 6", 32'(got_vec), 32'hA6);
      do_write(2'd2, 8'h0E);
      chk_intr("R8 specific EOI level 6");

      // R9 spurious acknowledge
      chk(intr == 1'b0, "R9 idle before spurious", 32'(intr), 32'd0);
      do_ack("R9 spurious");
      chk(got_vec == 8'hA7, "R9 spurious vector", 32'(got_vec), 32'hA7);
      set_irq(8'hEA);
      chk(intr == 1'b1, "R9 no in-service left by spurious", 32'(intr), 32'd1);
      do_ack("R9 real level 7");
      do_write(2'd2, 8'h00);

      // R10 address 3 ignored
      do_write(2'd3, 8'hFF);
      set_irq(8'hEB);
      chk(intr == 1'b1, "R10 mask kept after addr 3", 32'(intr), 32'd1);
      do_ack("R10 base kept");
      chk(got_vec == 8'hA0, "R10 base kept after addr 3", 32'(got_vec), 32'hA0);
      do_write(2'd2, 8'h00);

      // R2 held line does not re-request
      repeat (4) @(negedge clk);
      chk(intr == 1'b0, "R2 held line no new request", 32'(intr), 32'd0);

      // R4 simultaneous rising edges
      set_irq(8'hFF);
      do_ack("R4 simultaneous");
      chk(got_vec == 8'hA2, "R4 input 2 beats 4", 32'(got_vec), 32'hA2);
      do_write(2'd2, 8'h00);
      chk(intr == 1'b1, "R4 input 4 next", 32'(intr), 32'd1);
      do_ack("R4 second winner");
      chk(got_vec == 8'hA4, "R4 vector 4", 32'(got_vec), 32'hA4);
      do_write(2'd2, 8'h00);
      set_irq(8'h00);

      // Random mix checked against the model
      for (int n = 0; n < 600; n++) begin
         int op;
         op = int'($urandom_range(0, 9));
         case (op)
            0, 1, 2: set_irq(irq ^ 8'($urandom));
            3:       do_write(2'd0, 8'($urandom) & 8'($urandom));
            4, 5:    do_ack("R4 R5 random ack");
            6:       do_write(2'd2, 8'h00);
            7:       do_write(2'd2, {4'h0, 1'b1, 3'($urandom)});
            8:       do_write(2'd1, 8'($urandom));
            default: do_write(2'd3, 8'($urandom));
         endcase
         chk_intr("R6 random intr vs model");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule